// File: doc/BRIEF.md
# Protected Page Translation Cache

This block is a small, fully associative cache of page translations. Each entry maps a virtual page number, qualified by a process identifier, to a physical page number. A lookup compares the presented page number and process identifier against every entry in parallel. The hit flag, the physical page number and the protection trap all settle in the same cycle as the request, with no register on the lookup path. The page offset never enters the block: the requester joins it to the returned physical page number.

Each entry also carries read, write and execute permission bits. The kind of access presented with a lookup is compared against these bits. When the access is not permitted, the block raises a trap and withholds the translation.

A miss tells the requester to start a page-table walk. The walker then installs the result through the fill port. A round-robin pointer picks the victim entry, unless the filled page is already cached for that process, in which case the existing entry is rewritten in place. A flush input invalidates every entry at once, for example on an address-space teardown.

Top module: `tlb_xlate_guard`

## Requirements
- R1: After reset no entry is valid. Every lookup gives lk_hit=0, lk_fault=0 and lk_ppn=0.
- R2: After a fill has been captured on a clock edge, a lookup with the same page number and process identifier whose access is permitted gives lk_hit=1 and the filled physical page number, combinationally in the same cycle as the lookup.
- R3: The process identifier is part of the tag. A lookup with a matching page number but a different process identifier misses, and two processes may hold entries for the same page number at the same time.
- R4: Access code 2'b00 (load) needs permission bit 0 (read), and code 2'b10 (fetch) needs bit 2 (execute). The reserved code 2'b11 is never permitted. A hit whose access is not permitted gives lk_fault=1.
- R5: Access code 2'b01 (store) needs permission bit 1 (write). A store that hits an entry without that bit, such as a read/execute page, gives lk_fault=1.
- R6: A fetch that hits an entry without the execute bit, such as a read/write page, gives lk_fault=1. Whenever lk_fault=1, lk_ppn reads 0.
- R7: A lookup that matches no valid entry gives lk_hit=0, lk_fault=0 and lk_ppn=0. A fault is reported only on a hit.
- R8: A fill of a page not already cached for that process writes the entry at the round-robin pointer and then advances the pointer by one, wrapping. After ENTRIES further new fills, the oldest entry is evicted.
- R9: A fill whose page number and process identifier match a valid entry rewrites that entry's physical page number and permissions. It does not advance the pointer, and at most one entry ever matches a lookup.
- R10: flush_all clears every entry in one cycle. A fill in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_pid | input | PID_W | Lookup process identifier |
| lk_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| lk_hit | output | 1 | A valid entry matches the lookup |
| lk_fault | output | 1 | Protection trap: hit with access not permitted |
| lk_ppn | output | PPN_W | Physical page number, zero unless hit and permitted |
| fill_en | input | 1 | Install a translation on this clock edge |
| fill_vpn | input | VPN_W | Virtual page number to install |
| fill_pid | input | PID_W | Process identifier to install |
| fill_ppn | input | PPN_W | Physical page number to install |
| fill_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| flush_all | input | 1 | Invalidate all entries |

## Verification
On every cycle, the assertions check four things. No more than one entry matches a lookup. A trap appears only together with a hit. A miss drives neither a trap nor a page number. The cycle after a flush always misses. They also follow the victim pointer: it steps by exactly one on each new-page fill and holds on overwrites, flushes and idle cycles. The values returned for hits, the effect of each permission bit on each access kind, isolation between processes, in-place overwrite and eviction after the pointer wraps depend on stored contents. Only the bench's scenarios show these.

// File: rtl/tlbg_pkg.sv
package tlbg_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   typedef struct packed {
      logic x;
      logic w;
      logic r;
   } perm_t;

   function automatic logic perm_allows(perm_t p, acc_e a);
      case (a)
         ACC_LOAD:  return p.r;
         ACC_STORE: return p.w;
         ACC_FETCH: return p.x;
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/tlbg_entry.sv
module tlbg_entry
   import tlbg_pkg::*;
#(
   parameter int VPN_W = 20,
   parameter int PID_W = 8,
   parameter int PPN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             we,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PID_W-1:0] wr_pid,
   input  logic [PPN_W-1:0] wr_ppn,
   input  perm_t            wr_perm,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [PID_W-1:0] lk_pid,
   output logic             lk_match,
   output logic             wr_match,
   output logic [PPN_W-1:0] ppn,
   output perm_t            perm
);

   logic             vld_q;
   logic [VPN_W-1:0] vpn_q;
   logic [PID_W-1:0] pid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         vpn_q <= '0;
         pid_q <= '0;
         ppn   <= '0;
         perm  <= '0;
      end else if (clr) begin
         vld_q <= 1'b0;
      end else if (we) begin
         vld_q <= 1'b1;
         vpn_q <= wr_vpn;
         pid_q <= wr_pid;
         ppn   <= wr_ppn;
         perm  <= wr_perm;
      end
   end

   assign lk_match = vld_q && (vpn_q == lk_vpn) && (pid_q == lk_pid);
   assign wr_match = vld_q && (vpn_q == wr_vpn) && (pid_q == wr_pid);

endmodule

// File: rtl/tlbg_rr_ptr.sv
module tlbg_rr_ptr #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [IDX_W-1:0] ptr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (step) ptr <= ptr + 1'b1;
   end

endmodule

// File: rtl/tlbg_onehot_mux.sv
module tlbg_onehot_mux
   import tlbg_pkg::*;
#(
   parameter int N     = 16,
   parameter int PPN_W = 16
) (
   input  logic [N-1:0]            sel,
   input  logic [N-1:0][PPN_W-1:0] ppn_in,
   input  perm_t [N-1:0]           perm_in,
   output logic [PPN_W-1:0]        ppn_out,
   output perm_t                   perm_out
);

   always_comb begin
      ppn_out  = '0;
      perm_out = '0;
      for (int i = 0; i < N; i++) begin
         ppn_out  = ppn_out  | (ppn_in[i]  & {PPN_W{sel[i]}});
         perm_out = perm_out | (perm_in[i] & {3{sel[i]}});
      end
   end

endmodule

// File: rtl/tlb_xlate_guard.sv
module tlb_xlate_guard
   import tlbg_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PID_W   = 8,
   parameter int PPN_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [PID_W-1:0] lk_pid,
   input  logic [1:0]       lk_acc,
   output logic             lk_hit,
   output logic             lk_fault,
   output logic [PPN_W-1:0] lk_ppn,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PID_W-1:0] fill_pid,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic [2:0]       fill_perm,
   input  logic             flush_all
);

   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (VPN_W < 1 || PID_W < 1 || PPN_W < 1) begin : g_bad_width
      $error("field widths must be positive");
   end

   logic [ENTRIES-1:0]            lk_match;
   logic [ENTRIES-1:0]            fl_match;
   logic [ENTRIES-1:0]            we;
   logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
   perm_t [ENTRIES-1:0]           ent_perm;
   logic [IDX_W-1:0]              rr_ptr;
   logic                          fill_go;
   logic                          fill_hit;
   logic [PPN_W-1:0]              sel_ppn;
   perm_t                         sel_perm;
   logic                          allowed;

   assign fill_go  = fill_en && !flush_all;
   assign fill_hit = |fl_match;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      assign we[i] = fill_go && (fill_hit ? fl_match[i] : (rr_ptr == IDX_W'(i)));

      tlbg_entry #(
         .VPN_W (VPN_W),
         .PID_W (PID_W),
         .PPN_W (PPN_W)
      ) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (flush_all),
         .we       (we[i]),
         .wr_vpn   (fill_vpn),
         .wr_pid   (fill_pid),
         .wr_ppn   (fill_ppn),
         .wr_perm  (perm_t'(fill_perm)),
         .lk_vpn   (lk_vpn),
         .lk_pid   (lk_pid),
         .lk_match (lk_match[i]),
         .wr_match (fl_match[i]),
         .ppn      (ent_ppn[i]),
         .perm     (ent_perm[i])
      );
   end

   tlbg_rr_ptr #(
      .IDX_W (IDX_W)
   ) u_rr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (fill_go && !fill_hit),
      .ptr   (rr_ptr)
   );

   tlbg_onehot_mux #(
      .N     (ENTRIES),
      .PPN_W (PPN_W)
   ) u_mux (
      .sel      (lk_match),
      .ppn_in   (ent_ppn),
      .perm_in  (ent_perm),
      .ppn_out  (sel_ppn),
      .perm_out (sel_perm)
   );

   assign allowed  = perm_allows(sel_perm, acc_e'(lk_acc));
   assign lk_hit   = |lk_match;
   assign lk_fault = lk_hit && !allowed;
   assign lk_ppn   = (lk_hit && allowed) ? sel_ppn : '0;

endmodule

// File: rtl/tlbg_checker.sv
module tlbg_checker #(
   parameter int ENTRIES = 16,
   parameter int PPN_W   = 16,
   parameter int IDX_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_hit,
   input logic               lk_fault,
   input logic [PPN_W-1:0]   lk_ppn,
   input logic [ENTRIES-1:0] match_vec,
   input logic               fill_en,
   input logic               fill_hit,
   input logic               flush_all,
   input logic [IDX_W-1:0]   victim
);

   // R9
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   // R7
   fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> lk_hit);

   // R7
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (!lk_fault && lk_ppn == '0));

   // R6
   fault_no_ppn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> lk_ppn == '0);

   // R10
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !lk_hit);

   // R8
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !flush_all && !fill_hit) |=> victim == IDX_W'($past(victim) + 1'b1));

   // R9
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_en && !flush_all && !fill_hit) |=> $stable(victim));

endmodule

bind tlb_xlate_guard tlbg_checker #(
   .ENTRIES (ENTRIES),
   .PPN_W   (PPN_W),
   .IDX_W   (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_hit    (lk_hit),
   .lk_fault  (lk_fault),
   .lk_ppn    (lk_ppn),
   .match_vec (lk_match),
   .fill_en   (fill_en),
   .fill_hit  (fill_hit),
   .flush_all (flush_all),
   .victim    (rr_ptr)
);

// File: tb/tlb_xlate_guard_bench.sv
`timescale 1ns/1ps
module tlb_xlate_guard_bench;

   localparam int ENTRIES = 16;
   localparam int VPN_W   = 20;
   localparam int PID_W   = 8;
   localparam int PPN_W   = 16;

   localparam logic [1:0] OP_LOOK = 2'd0;
   localparam logic [1:0] OP_FILL = 2'd1;

   localparam logic [1:0] LD = 2'b00;
   localparam logic [1:0] ST = 2'b01;
   localparam logic [1:0] FE = 2'b10;
   localparam logic [1:0] RS = 2'b11;

   typedef struct packed {
      logic [1:0]       op;
      logic [VPN_W-1:0] vpn;
      logic [PID_W-1:0] pid;
      logic [PPN_W-1:0] ppn;
      logic [2:0]       perm;
      logic [1:0]       acc;
      logic             eh;
      logic             ef;
      logic [PPN_W-1:0] eppn;
      logic [7:0]       req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{OP_LOOK, 20'h00010, 8'd1, 16'h0000, 3'b000, LD, 1'b0, 1'b0, 16'h0000, 8'd1},  // R1 empty
      '{OP_FILL, 20'h00010, 8'd1, 16'h0A10, 3'b011, LD, 1'b0, 1'b0, 16'h0000, 8'd2},  // R2 RW page
      '{OP_LOOK, 20'h00010, 8'd1, 16'h0000, 3'b000, LD, 1'b1, 1'b0, 16'h0A10, 8'd2},  // R2
      '{OP_LOOK, 20'h00010, 8'd1, 16'h0000, 3'b000, ST, 1'b1, 1'b0, 16'h0A10, 8'd2},  // R2
      '{OP_LOOK, 20'h00010, 8'd1, 16'h0000, 3'b000, FE, 1'b1, 1'b1, 16'h0000, 8'd6},  // R6
      '{OP_LOOK, 20'h00010, 8'd2, 16'h0000, 3'b000, LD, 1'b0, 1'b0, 16'h0000, 8'd3},  // R3
      '{OP_FILL, 20'h00020, 8'd1, 16'h0B20, 3'b101, LD, 1'b0, 1'b0, 16'h0000, 8'd5},  // R5 RX page
      '{OP_LOOK, 20'h00020, 8'd1, 16'h0000, 3'b000, ST, 1'b1, 1'b1, 16'h0000, 8'd5},  // R5
      '{OP_LOOK, 20'h00020, 8'd1, 16'h0000, 3'b000, FE, 1'b1, 1'b0, 16'h0B20, 8'd4},  // R4
      '{OP_FILL, 20'h00030, 8'd1, 16'h0C30, 3'b010, LD, 1'b0, 1'b0, 16'h0000, 8'd4},  // R4 W only
      '{OP_LOOK, 20'h00030, 8'd1, 16'h0000, 3'b000, LD, 1'b1, 1'b1, 16'h0000, 8'd4},  // R4
      '{OP_LOOK, 20'h00010, 8'd1, 16'h0000, 3'b000, RS, 1'b1, 1'b1, 16'h0000, 8'd4},  // R4 reserved
      '{OP_FILL, 20'h00010, 8'd2, 16'h0C10, 3'b111, LD, 1'b0, 1'b0, 16'h0000, 8'd3},  // R3
      '{OP_LOOK, 20'h00010, 8'd2, 16'h0000, 3'b000, FE, 1'b1, 1'b0, 16'h0C10, 8'd3},  // R3
      '{OP_LOOK, 20'h00010, 8'd1, 16'h0000, 3'b000, LD, 1'b1, 1'b0, 16'h0A10, 8'd3},  // R3
      '{OP_FILL, 20'h00010, 8'd1, 16'h0D10, 3'b001, LD, 1'b0, 1'b0, 16'h0000, 8'd9},  // R9 rewrite
      '{OP_LOOK, 20'h00010, 8'd1, 16'h0000, 3'b000, LD, 1'b1, 1'b0, 16'h0D10, 8'd9},  // R9
      '{OP_LOOK, 20'h00010, 8'd1, 16'h0000, 3'b000, ST, 1'b1, 1'b1, 16'h0000, 8'd9}   // R9
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic [PID_W-1:0] lk_pid = '0;
   logic [1:0]       lk_acc = '0;
   logic             lk_hit;
   logic             lk_fault;
   logic [PPN_W-1:0] lk_ppn;
   logic             fill_en = 1'b0;
   logic [VPN_W-1:0] fill_vpn = '0;
   logic [PID_W-1:0] fill_pid = '0;
   logic [PPN_W-1:0] fill_ppn = '0;
   logic [2:0]       fill_perm = '0;
   logic             flush_all = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tlb_xlate_guard #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PID_W   (PID_W),
      .PPN_W   (PPN_W)
   ) u_tlb_xlate_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_vpn    (lk_vpn),
      .lk_pid    (lk_pid),
      .lk_acc    (lk_acc),
      .lk_hit    (lk_hit),
      .lk_fault  (lk_fault),
      .lk_ppn    (lk_ppn),
      .fill_en   (fill_en),
      .fill_vpn  (fill_vpn),
      .fill_pid  (fill_pid),
      .fill_ppn  (fill_ppn),
      .fill_perm (fill_perm),
      .flush_all (flush_all)
   );

   task automatic look(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                       input logic [1:0] a, input logic eh, input logic ef,
                       input logic [PPN_W-1:0] eppn, input int req);
      @(negedge clk);
      lk_vpn = v;
      lk_pid = p;
      lk_acc = a;
      #1;
      n_chk++;
      if (lk_hit !== eh || lk_fault !== ef || lk_ppn !== eppn) begin
         n_bad++;
         $display("FAIL R%0d vpn=%h pid=%0d acc=%0d: got hit=%b fault=%b ppn=%h, expected hit=%b fault=%b ppn=%h",
                  req, v, p, a, lk_hit, lk_fault, lk_ppn, eh, ef, eppn);
      end
   endtask

   task automatic fill(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                       input logic [PPN_W-1:0] pp, input logic [2:0] pm,
                       input logic fl);
      @(negedge clk);
      fill_en   = 1'b1;
      fill_vpn  = v;
      fill_pid  = p;
      fill_ppn  = pp;
      fill_perm = pm;
      flush_all = fl;
      @(negedge clk);
      fill_en   = 1'b0;
      flush_all = 1'b0;
   endtask

   task automatic flush();
      @(negedge clk);
      flush_all = 1'b1;
      @(negedge clk);
      flush_all = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      look(20'h00000, 8'd0, LD, 1'b0, 1'b0, 16'h0, 1);
      look(20'hFFFFF, 8'hFF, FE, 1'b0, 1'b0, 16'h0, 1);

      for (int k = 0; k < NV; k++) begin
         if (VEC[k].op == OP_FILL)
            fill(VEC[k].vpn, VEC[k].pid, VEC[k].ppn, VEC[k].perm, 1'b0);
         else
            look(VEC[k].vpn, VEC[k].pid, VEC[k].acc, VEC[k].eh, VEC[k].ef,
                 VEC[k].eppn, int'(VEC[k].req));
      end

      // R10 flush clears everything
      flush();
      look(20'h00010, 8'd1, LD, 1'b0, 1'b0, 16'h0, 10);
      look(20'h00010, 8'd2, LD, 1'b0, 1'b0, 16'h0, 10);
      look(20'h00020, 8'd1, FE, 1'b0, 1'b0, 16'h0, 10);
      // R10 fill dropped when flushed in the same cycle
      fill(20'h00040, 8'd3, 16'h0E40, 3'b111, 1'b1);
      look(20'h00040, 8'd3, LD, 1'b0, 1'b0, 16'h0, 10);

      // R8 round-robin fill of every entry, then one more evicts the oldest
      for (int i = 0; i < ENTRIES; i++)
         fill(VPN_W'(32'h100 + i), 8'd5, PPN_W'(32'h2000 + i), 3'b001, 1'b0);
      look(20'h00100, 8'd5, LD, 1'b1, 1'b0, 16'h2000, 8);
      look(VPN_W'(32'h100 + ENTRIES - 1), 8'd5, LD, 1'b1, 1'b0, PPN_W'(32'h2000 + ENTRIES - 1), 8);
      fill(20'h00200, 8'd5, 16'h3000, 3'b001, 1'b0);
      look(20'h00100, 8'd5, LD, 1'b0, 1'b0, 16'h0, 8);
      look(20'h00101, 8'd5, LD, 1'b1, 1'b0, 16'h2001, 8);
      look(20'h00200, 8'd5, LD, 1'b1, 1'b0, 16'h3000, 8);

      // R9 rewrite in place does not move the victim pointer
      fill(20'h00105, 8'd5, 16'h4105, 3'b001, 1'b0);
      fill(20'h00300, 8'd5, 16'h5300, 3'b001, 1'b0);
      look(20'h00101, 8'd5, LD, 1'b0, 1'b0, 16'h0, 9);
      look(20'h00105, 8'd5, LD, 1'b1, 1'b0, 16'h4105, 9);
      look(20'h00102, 8'd5, LD, 1'b1, 1'b0, 16'h2002, 9);
      look(20'h00300, 8'd5, LD, 1'b1, 1'b0, 16'h5300, 9);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got run still busy, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule